// File: doc/BRIEF.md
# Repeated-Addition Unsigned Multiplier

This block multiplies two unsigned operands of `OPW` bits each and returns a `2*OPW`-bit product. It adds the multiplicand into an accumulator once for every unit of the multiplier. A small controller sequences a datapath of three registers: an accumulator, a down-counter and a multiplicand copy. A caller waits for `ready`, drives both operands and pulses `start` for one cycle. It keeps the operands steady until `ready` comes back, then reads `product`. The product stays on the output until the next operation begins.

The controller has five named states:

- `ST_IDLE` waits for work and raises `ready`.
- `ST_ZERO` is the shortcut taken when either operand is zero.
- `ST_LOAD` primes the registers for a nonzero multiply.
- `ST_OP` adds the multiplicand into the accumulator.
- `ST_DEC` exists only in the shared-adder build. There it holds the counter decrement and the loop test.

The transitions are:

- idle-to-zero: `start` with a zero operand.
- idle-to-load: `start` with two nonzero operands.
- zero-to-idle and load-to-op: unconditional.
- In the separate-adder build, op-to-op while the decremented count is nonzero, and op-to-idle when it reaches zero.
- In the shared build, op-to-dec always, then dec-to-op or dec-to-idle on the same count test.

The parameter `SHARE` selects the variant. With `SHARE=0`, the accumulation and the decrement happen in one cycle on separate arithmetic units. With `SHARE=1`, a single `2*OPW`-bit adder serves both operations in alternating states.

Top module: `mult_rep_add`

## Requirements
- R1: Asserting `arst` at any time returns the block to idle with no clock edge: `ready` becomes 1 and `product` becomes 0.
- R2: `ready` is 1 only while idle. A `start` sampled high at a rising edge while idle begins an operation, and `ready` is 0 after that edge.
- R3: If either operand is zero at start, `product` is 0 and `ready` returns 2 rising edges after the edge that sampled `start`.
- R4: With `SHARE=0` and both operands nonzero, `product` equals a_in*b_in and `ready` returns b_in+2 edges after the start edge.
- R5: With `SHARE=1` and both operands nonzero, `product` equals a_in*b_in and `ready` returns 2*b_in+2 edges after the start edge.
- R6: While idle with `start` low, `product` keeps its last value, even if the operands change.
- R7: A `start` pulse while busy has no effect: it changes neither the result nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Begin a multiply when sampled high while idle |
| a_in | input | OPW | Multiplicand, unsigned |
| b_in | input | OPW | Multiplier (iteration count), unsigned |
| product | output | 2*OPW | Accumulator contents, the result once idle |
| ready | output | 1 | High while idle and able to accept a start |

## Verification
The bench builds four copies of the block:

- 4-bit operands with `SHARE=0`.
- 4-bit operands with `SHARE=1`.
- 8-bit operands with `SHARE=0`.
- 8-bit operands with `SHARE=1`.

The two 4-bit builds are swept over every operand pair. This covers every zero-shortcut case, the single-iteration loop and the longest loop in both schedules, with exact cycle counts. The 8-bit builds take corner pairs, including a zero on each side, 1x1, a lopsided pair in each order and the full-scale 255x255. These show that the full product width and long counts behave. The bench also checks a start pulse during a busy phase and an asynchronous reset in the middle of an operation.

// File: rtl/mra_pkg.sv
package mra_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ZERO = 3'd1,
        ST_LOAD = 3'd2,
        ST_OP   = 3'd3,
        ST_DEC  = 3'd4
    } mra_state_e;

endpackage

// File: rtl/mra_ctrl.sv
module mra_ctrl
    import mra_pkg::*;
#(
    parameter bit SHARE = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic start,
    input  logic zero_op,
    input  logic cnt_last,
    output logic ld,
    output logic acc_en,
    output logic dec_en,
    output logic ready
);

    mra_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) state_q <= ST_IDLE;
        else      state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = zero_op ? ST_ZERO : ST_LOAD;
            ST_ZERO: state_d = ST_IDLE;
            ST_LOAD: state_d = ST_OP;
            ST_OP: begin
                if (SHARE)         state_d = ST_DEC;
                else if (cnt_last) state_d = ST_IDLE;
                else               state_d = ST_OP;
            end
            ST_DEC:  state_d = cnt_last ? ST_IDLE : ST_OP;
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        ld     = 1'b0;
        acc_en = 1'b0;
        dec_en = 1'b0;
        ready  = 1'b0;
        unique case (state_q)
            ST_IDLE: ready = 1'b1;
            ST_ZERO: ld    = 1'b1;
            ST_LOAD: ld    = 1'b1;
            ST_OP: begin
                acc_en = 1'b1;
                dec_en = !SHARE;
            end
            ST_DEC:  dec_en = 1'b1;
            default: ready  = 1'b0;
        endcase
    end

    // R3: a zero operand at start takes the shortcut state
    a_r3_zero_shortcut: assert property (@(posedge clk) disable iff (arst)
        (state_q == ST_IDLE && start && zero_op) |=> (state_q == ST_ZERO));

    // R5: in the shared schedule every accumulate is followed by a decrement
    a_r5_alternate: assert property (@(posedge clk) disable iff (arst)
        (SHARE && state_q == ST_OP) |=> (state_q == ST_DEC));

endmodule

// File: rtl/mra_dpath.sv
module mra_dpath #(
    parameter int OPW   = 8,
    parameter bit SHARE = 1'b0,
    localparam int PW   = 2 * OPW
) (
    input  logic           clk,
    input  logic           arst,
    input  logic           ld,
    input  logic           acc_en,
    input  logic           dec_en,
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    output logic           zero_op,
    output logic           cnt_last,
    output logic [PW-1:0]  r_out
);

    logic [PW-1:0]  r_q;
    logic [OPW-1:0] n_q;
    logic [OPW-1:0] a_q;
    logic [PW-1:0]  r_nxt;
    logic [OPW-1:0] n_nxt;

    assign zero_op = (a_in == '0) || (b_in == '0);

    generate
        if (SHARE) begin : g_shared
            logic [PW-1:0] add_x, add_y, add_s;
            always_comb begin
                if (dec_en) begin
                    add_x = {{OPW{1'b0}}, n_q};
                    add_y = {PW{1'b1}};
                end else begin
                    add_x = r_q;
                    add_y = {{OPW{1'b0}}, a_q};
                end
            end
            assign add_s = add_x + add_y;
            assign r_nxt = add_s;
            assign n_nxt = add_s[OPW-1:0];
        end else begin : g_split
            assign r_nxt = r_q + {{OPW{1'b0}}, a_q};
            assign n_nxt = n_q - 1'b1;
        end
    endgenerate

    assign cnt_last = dec_en && (n_nxt == '0);

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            r_q <= '0;
            n_q <= '0;
            a_q <= '0;
        end else begin
            if (ld) begin
                r_q <= '0;
                n_q <= b_in;
                a_q <= a_in;
            end else begin
                if (acc_en) r_q <= r_nxt;
                if (dec_en) n_q <= n_nxt;
            end
        end
    end

    assign r_out = r_q;

    // R3/R4: loading always starts the accumulator from zero
    a_r4_load_clears: assert property (@(posedge clk) disable iff (arst)
        ld |=> (r_q == '0));

    // R4: the counter falls by exactly one per decrement
    a_r4_count_down: assert property (@(posedge clk) disable iff (arst)
        (dec_en && !ld) |=> (n_q == $past(n_q) - 1'b1));

    // R7: the multiplicand copy only changes on a load
    a_r7_multiplicand_held: assert property (@(posedge clk) disable iff (arst)
        !ld |=> $stable(a_q));

endmodule

// File: rtl/mult_rep_add.sv
module mult_rep_add #(
    parameter int OPW   = 8,
    parameter bit SHARE = 1'b0,
    localparam int PW   = 2 * OPW
) (
    input  logic           clk,
    input  logic           arst,
    input  logic           start,
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    output logic [PW-1:0]  product,
    output logic           ready
);

    logic ld, acc_en, dec_en, zero_op, cnt_last;

    mra_ctrl #(.SHARE(SHARE)) u_ctrl (
        .clk      (clk),
        .arst     (arst),
        .start    (start),
        .zero_op  (zero_op),
        .cnt_last (cnt_last),
        .ld       (ld),
        .acc_en   (acc_en),
        .dec_en   (dec_en),
        .ready    (ready)
    );

    mra_dpath #(.OPW(OPW), .SHARE(SHARE)) u_dpath (
        .clk      (clk),
        .arst     (arst),
        .ld       (ld),
        .acc_en   (acc_en),
        .dec_en   (dec_en),
        .a_in     (a_in),
        .b_in     (b_in),
        .zero_op  (zero_op),
        .cnt_last (cnt_last),
        .r_out    (product)
    );

    // R2: an accepted start leaves idle on the next edge
    a_r2_start_leaves_idle: assert property (@(posedge clk) disable iff (arst)
        (ready && start) |=> !ready);

    // R6: the result is held while idle without a start
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (arst)
        (ready && !start) |=> $stable(product));

endmodule

// File: tb/tb_mult_rep_add.sv
module tb_mult_rep_add;

    logic clk = 1'b0;
    logic arst = 1'b1;
    always #5 clk = ~clk;

    logic        st [4];
    logic [7:0]  av [4];
    logic [7:0]  bv [4];
    logic [15:0] prod [4];
    logic        rdy [4];
    logic [7:0]  p4n, p4s;

    int checks = 0;
    int errors = 0;

    // k=0: 8-bit split, k=1: 4-bit split, k=2: 4-bit shared, k=3: 8-bit shared
    mult_rep_add #(.OPW(8), .SHARE(1'b0)) dut (
        .clk(clk), .arst(arst), .start(st[0]), .a_in(av[0]), .b_in(bv[0]),
        .product(prod[0]), .ready(rdy[0]));
    mult_rep_add #(.OPW(4), .SHARE(1'b0)) dut_n4 (
        .clk(clk), .arst(arst), .start(st[1]), .a_in(av[1][3:0]), .b_in(bv[1][3:0]),
        .product(p4n), .ready(rdy[1]));
    mult_rep_add #(.OPW(4), .SHARE(1'b1)) dut_s4 (
        .clk(clk), .arst(arst), .start(st[2]), .a_in(av[2][3:0]), .b_in(bv[2][3:0]),
        .product(p4s), .ready(rdy[2]));
    mult_rep_add #(.OPW(8), .SHARE(1'b1)) dut_s8 (
        .clk(clk), .arst(arst), .start(st[3]), .a_in(av[3]), .b_in(bv[3]),
        .product(prod[3]), .ready(rdy[3]));

    assign prod[1] = {8'd0, p4n};
    assign prod[2] = {8'd0, p4s};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_shared(input int k);
        return (k == 2) || (k == 3);
    endfunction

    // One full multiply on instance k; optionally pulse start while busy.
    task automatic run_op(input int k, input int x, input int y, input bit poke);
        int cyc;
        int exp_lat;
        string rq;
        if (x == 0 || y == 0) begin
            exp_lat = 2;
            rq = "R3";
        end else if (is_shared(k)) begin
            exp_lat = 2 * y + 2;
            rq = "R5";
        end else begin
            exp_lat = y + 2;
            rq = "R4";
        end
        @(negedge clk);
        av[k] = 8'(x);
        bv[k] = 8'(y);
        st[k] = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                st[k] = 1'b0;
                check("R2 ready low after accepted start", int'(rdy[k]), 0);
            end
            if (poke && cyc == 2 && !rdy[k]) st[k] = 1'b1;
            if (cyc == 3) st[k] = 1'b0;
        end while (!rdy[k] && cyc < 4000);
        st[k] = 1'b0;
        check({rq, poke ? " R7 latency" : " latency"}, cyc, exp_lat);
        check({rq, poke ? " R7 product" : " product"}, int'(prod[k]), x * y);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            st[k] = 1'b0;
            av[k] = 8'd0;
            bv[k] = 8'd0;
        end
        #1;
        for (int k = 0; k < 4; k++) begin
            check("R1 ready in reset", int'(rdy[k]), 1);
            check("R1 product in reset", int'(prod[k]), 0);
        end
        repeat (3) @(negedge clk);
        arst = 1'b0;

        // exhaustive 4-bit sweeps, both schedules
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++) begin
                run_op(1, x, y, 1'b0);
                run_op(2, x, y, (x + y) % 3 == 0);
            end

        // 8-bit corner pairs, both schedules
        for (int k = 0; k < 4; k += 3) begin
            run_op(k, 0, 255, 1'b0);
            run_op(k, 255, 0, 1'b0);
            run_op(k, 1, 1, 1'b1);
            run_op(k, 200, 3, 1'b1);
            run_op(k, 3, 200, 1'b0);
            run_op(k, 128, 2, 1'b0);
            run_op(k, 255, 255, 1'b1);
        end

        // R6: product held while idle with operands changing
        run_op(0, 17, 9, 1'b0);
        @(negedge clk);
        av[0] = 8'd99;
        bv[0] = 8'd0;
        repeat (6) @(negedge clk);
        check("R6 product held in idle", int'(prod[0]), 153);
        check("R6 ready stays high", int'(rdy[0]), 1);

        // R1: asynchronous reset in the middle of an operation
        av[0] = 8'd5;
        bv[0] = 8'd40;
        st[0] = 1'b1;
        @(negedge clk);
        st[0] = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 busy before reset", int'(rdy[0]), 0);
        #2;
        arst = 1'b1;
        #1;
        check("R1 ready after async reset", int'(rdy[0]), 1);
        check("R1 product after async reset", int'(prod[0]), 0);
        @(negedge clk);
        arst = 1'b0;
        run_op(0, 6, 7, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule